// File: doc/BRIEF.md
# Age-Threshold Read Arbiter with Starvation Promotion

This block picks at most one read request per cycle from a request queue of up to `ENTRIES` slots. Each slot presents a valid bit, a region tag (top or bottom of a die stack), an arrival timestamp and an eligibility bit from an external activity-limit checker. The arbiter runs its own free-running timestamp counter and hands it out so the queue can stamp arrivals. It also tracks a moving average of the latencies of completed reads.

A request becomes urgent once its age exceeds about 1.2 times that average. Urgent requests win over all others. When a top-region request is urgent, bottom-region requests are held back so that the activity budget frees up for the starved top request. Within a priority class the oldest request wins, and ties go to the lowest slot index. The grant is combinational from the current inputs and the registered average, so the queue can act on it in the same cycle.

Top module: `age_promote_arb`

## Requirements
- R1: `grant` has at most one bit set. A bit is set only for a slot with both `req_valid` and `req_elig` high. An ineligible slot is never granted, even when it is urgent.
- R2: `ts_now` is 0 during reset. It then rises by 1 on every clock and wraps modulo 2^TS_W.
- R3: The age of a slot is `(ts_now - ts) mod 2^TS_W`, so it stays correct across counter wrap.
- R4: An accumulator resets to `AVG_INIT * 2^EMA_SH`. On each cycle with `cmp_valid` high it becomes `acc - (acc >> EMA_SH) + cmp_lat`, and otherwise it holds. The average is `acc >> EMA_SH`.
- R5: The threshold is `avg + avg/8 + avg/16 + avg/32`, with each term rounded down. A valid slot is urgent when its age is strictly greater than the threshold.
- R6: If any grantable slot is urgent, the grant goes to an urgent slot.
- R7: Within the winning class (urgent, or else all grantable), the slot with the largest age wins. Equal ages go to the lowest index.
- R8: `req_top` = 1 marks a top-region slot and 0 a bottom-region slot. While any valid top slot is urgent (eligible or not), no bottom slot is granted.
- R9: If at least one slot is grantable under R1 and R8, exactly one grant is issued.
- R10: `grant_urgent` is 1 when the granted slot is urgent. It is 0 when the granted slot is not urgent, and 0 when nothing is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | ENTRIES | Slot holds a pending read |
| req_top | input | ENTRIES | 1 = top region, 0 = bottom region |
| req_elig | input | ENTRIES | Slot allowed by the activity-limit checker |
| req_ts | input | ENTRIES*TS_W | Arrival timestamps, slot i at bits [i*TS_W +: TS_W] |
| cmp_valid | input | 1 | A read completed this cycle |
| cmp_lat | input | LAT_W | Latency of the completed read in cycles |
| ts_now | output | TS_W | Current timestamp for stamping arrivals |
| grant | output | ENTRIES | One-hot selected slot, or zero |
| grant_urgent | output | 1 | Selected slot was promoted |

## Verification
A single-slot age sweep across the threshold pins down the strict comparison and the scaled average. That sweep is repeated after two runs of completions, one pushing the average up and one pulling it down, which separates a correct update from a stale or mis-weighted one. Ages large enough to cross the counter wrap show whether the subtraction is modular. Directed cases cover age ties, an urgent top slot that is ineligible but still blocks bottom traffic, and urgent slots that are never granted. A long pseudo-random run with forced age ties compares grant and urgency against an arithmetic model, which tells apart the class ordering, the age ordering, the index tie-break and the bottom hold.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  typedef enum logic {
    REGION_BOTTOM = 1'b0,
    REGION_TOP    = 1'b1
  } region_e;
endpackage

// File: rtl/lat_avg.sv
`timescale 1ns/1ps
module lat_avg #(
  parameter int LAT_W    = 16,
  parameter int EMA_SH   = 4,
  parameter int AVG_INIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic [LAT_W-1:0] cmp_lat,
  output logic [LAT_W:0]   thr
);
  localparam int ACC_W = LAT_W + EMA_SH;
  localparam int TW    = LAT_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [LAT_W-1:0] avg;

  // next state: exponential moving average, weight 2^-EMA_SH
  always_comb begin
    acc_d = acc_q;
    if (cmp_valid)
      acc_d = acc_q - (acc_q >> EMA_SH) + ACC_W'(cmp_lat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= ACC_W'(AVG_INIT * (2 ** EMA_SH));
    else if (cmp_valid)
      acc_q <= acc_d;
  end

  assign avg = acc_q[ACC_W-1:EMA_SH];

  // scale by 1 + 1/8 + 1/16 + 1/32 (about 1.2)
  assign thr = TW'(avg) + TW'(avg >> 3) + TW'(avg >> 4) + TW'(avg >> 5);

  assert_avg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(acc_q));
endmodule

// File: rtl/age_calc.sv
`timescale 1ns/1ps
module age_calc #(
  parameter int N     = 32,
  parameter int TS_W  = 16,
  parameter int LAT_W = 16
) (
  input  logic [TS_W-1:0]   ts_now,
  input  logic [N*TS_W-1:0] req_ts,
  input  logic [N-1:0]      req_valid,
  input  logic [LAT_W:0]    thr,
  output logic [N*TS_W-1:0] age,
  output logic [N-1:0]      urgent
);
  localparam int CW = ((TS_W > LAT_W + 1) ? TS_W : LAT_W + 1) + 1;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [TS_W-1:0] a;
    assign a = ts_now - req_ts[i*TS_W +: TS_W];
    assign age[i*TS_W +: TS_W] = a;
    assign urgent[i] = req_valid[i] && (CW'(a) > CW'(thr));
  end
endmodule

// File: rtl/oldest_tree.sv
`timescale 1ns/1ps
module oldest_tree #(
  parameter int N     = 32,
  parameter int KEY_W = 17
) (
  input  logic [N-1:0]       cand,
  input  logic [N*KEY_W-1:0] key,
  output logic               win_valid,
  output logic [(N > 1 ? $clog2(N) : 1)-1:0] win_idx
);
  localparam int LVL   = (N > 1) ? $clog2(N) : 1;
  localparam int P     = 1 << LVL;
  localparam int NODES = 2 * P - 1;

  logic             lv [P];
  logic [KEY_W-1:0] lk [P];

  // pad leaves to a power of two
  for (genvar k = 0; k < P; k++) begin : g_leaf
    if (k < N) begin : g_real
      assign lv[k] = cand[k];
      assign lk[k] = key[k*KEY_W +: KEY_W];
    end else begin : g_pad
      assign lv[k] = 1'b0;
      assign lk[k] = '0;
    end
  end

  logic             nv [NODES];
  logic [KEY_W-1:0] nk [NODES];
  logic [LVL-1:0]   ni [NODES];

  // heap-ordered tree, left child holds lower indices and wins ties
  always_comb begin
    for (int k = 0; k < P; k++) begin
      nv[P-1+k] = lv[k];
      nk[P-1+k] = lk[k];
      ni[P-1+k] = LVL'(k);
    end
    for (int n = P - 2; n >= 0; n--) begin
      if (nv[2*n+2] && (!nv[2*n+1] || (nk[2*n+2] > nk[2*n+1]))) begin
        nv[n] = 1'b1;
        nk[n] = nk[2*n+2];
        ni[n] = ni[2*n+2];
      end else begin
        nv[n] = nv[2*n+1];
        nk[n] = nk[2*n+1];
        ni[n] = ni[2*n+1];
      end
    end
  end

  assign win_valid = nv[0];
  assign win_idx   = ni[0];
endmodule

// File: rtl/age_promote_arb.sv
`timescale 1ns/1ps
module age_promote_arb #(
  parameter int ENTRIES  = 32,
  parameter int TS_W     = 16,
  parameter int LAT_W    = 16,
  parameter int EMA_SH   = 4,
  parameter int AVG_INIT = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ENTRIES-1:0]      req_valid,
  input  logic [ENTRIES-1:0]      req_top,
  input  logic [ENTRIES-1:0]      req_elig,
  input  logic [ENTRIES*TS_W-1:0] req_ts,
  input  logic                    cmp_valid,
  input  logic [LAT_W-1:0]        cmp_lat,
  output logic [TS_W-1:0]         ts_now,
  output logic [ENTRIES-1:0]      grant,
  output logic                    grant_urgent
);
  import arb_pkg::*;

  localparam int KEY_W = TS_W + 1;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // free-running timestamp
  logic [TS_W-1:0] ts_q, ts_d;
  always_comb ts_d = ts_q + TS_W'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_d;
  end
  assign ts_now = ts_q;

  logic [LAT_W:0] thr;
  lat_avg #(.LAT_W(LAT_W), .EMA_SH(EMA_SH), .AVG_INIT(AVG_INIT)) u_avg (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_lat(cmp_lat), .thr(thr)
  );

  logic [ENTRIES*TS_W-1:0] age;
  logic [ENTRIES-1:0]      urgent;
  age_calc #(.N(ENTRIES), .TS_W(TS_W), .LAT_W(LAT_W)) u_age (
    .ts_now(ts_q), .req_ts(req_ts), .req_valid(req_valid), .thr(thr),
    .age(age), .urgent(urgent)
  );

  // bottom hold while any top request is starving
  logic               top_starve;
  logic [ENTRIES-1:0] cand;
  logic [ENTRIES*KEY_W-1:0] key;
  always_comb begin
    top_starve = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (urgent[i] && (region_e'(req_top[i]) == REGION_TOP)) top_starve = 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      cand[i] = req_valid[i] && req_elig[i] &&
                !(top_starve && (region_e'(req_top[i]) == REGION_BOTTOM));
      key[i*KEY_W +: KEY_W] = {urgent[i], age[i*TS_W +: TS_W]};
    end
  end

  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  oldest_tree #(.N(ENTRIES), .KEY_W(KEY_W)) u_tree (
    .cand(cand), .key(key), .win_valid(win_valid), .win_idx(win_idx)
  );

  always_comb begin
    grant = '0;
    grant_urgent = 1'b0;
    if (win_valid) begin
      grant[win_idx] = 1'b1;
      grant_urgent   = urgent[win_idx];
    end
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_elig_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(req_valid & req_elig)) == '0);
  assert_ts_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_now == TS_W'($past(ts_now) + TS_W'(1)));
  assert_urgent_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand & urgent) != '0) |-> grant_urgent);
  assert_bottom_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((urgent & req_top) != '0) |-> ((grant & ~req_top) == '0));
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> (grant != '0));
  assert_urg_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> !grant_urgent);
endmodule

// File: tb/tb_age_promote_arb.sv
`timescale 1ns/1ps
module tb_age_promote_arb;
  localparam int N = 8, TS_W = 16, LAT_W = 16, EMA_SH = 4, AVG_INIT = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_valid = '0, req_top = '0, req_elig = '0;
  logic [N*TS_W-1:0] req_ts = '0;
  logic cmp_valid = 1'b0;
  logic [LAT_W-1:0] cmp_lat = '0;
  logic [TS_W-1:0] ts_now;
  logic [N-1:0] grant;
  logic grant_urgent;

  always #10 clk = ~clk;

  age_promote_arb #(.ENTRIES(N), .TS_W(TS_W), .LAT_W(LAT_W), .EMA_SH(EMA_SH),
                    .AVG_INIT(AVG_INIT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_top(req_top),
    .req_elig(req_elig), .req_ts(req_ts), .cmp_valid(cmp_valid), .cmp_lat(cmp_lat),
    .ts_now(ts_now), .grant(grant), .grant_urgent(grant_urgent));

  int checks = 0, fails = 0;
  int acc_m = AVG_INIT * 16;
  int m_v[N], m_e[N], m_t[N], m_age[N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int thr_m();
    int a = acc_m >> EMA_SH;
    return a + (a >> 3) + (a >> 4) + (a >> 5);
  endfunction

  // drive model arrays onto ports; called just after a falling edge
  task automatic apply();
    for (int i = 0; i < N; i++) begin
      req_valid[i] = m_v[i][0];
      req_elig[i]  = m_e[i][0];
      req_top[i]   = m_t[i][0];
      req_ts[i*TS_W +: TS_W] = TS_W'(int'(ts_now) - m_age[i]);
    end
  endtask

  task automatic expect_grant(output int idx, output int urg);
    int thr = thr_m();
    bit hold = 0, any_u = 0;
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] != 0 && m_t[i] != 0 && m_age[i] > thr) hold = 1;
    for (int i = 0; i < N; i++)
      if (m_v[i] != 0 && m_e[i] != 0 && !(hold && m_t[i] == 0) && m_age[i] > thr) any_u = 1;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] == 0 || m_e[i] == 0 || (hold && m_t[i] == 0)) continue;
      if (any_u && m_age[i] <= thr) continue;
      if (best < 0 || m_age[i] > m_age[best]) best = i;
    end
    idx = best;
    urg = (best >= 0) ? int'(m_age[best] > thr) : 0;
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_e[i] = 0; m_t[i] = 0; m_age[i] = 0;
    end
  endtask

  task automatic step_check(input string req);
    int ei, eu;
    @(negedge clk);
    apply();
    #5;
    expect_grant(ei, eu);
    chk(grant == ((ei >= 0) ? N'(1) << ei : '0), req, int'(grant),
        (ei >= 0) ? (1 << ei) : 0);
    chk(grant_urgent == eu[0], {req, " urgent flag"}, int'(grant_urgent), eu);
  endtask

  task automatic sweep_threshold(input string req);
    int t = thr_m();
    for (int a = t - 3; a <= t + 3; a++) begin
      clear_model();
      m_v[4] = 1; m_e[4] = 1; m_age[4] = a;
      step_check(req);
    end
  endtask

  task automatic complete(input int lat);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lat = LAT_W'(lat);
    @(negedge clk);
    cmp_valid = 1'b0;
    acc_m = acc_m - (acc_m >> EMA_SH) + lat;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0;
    clear_model();
    repeat (3) @(posedge clk);
    #5;
    chk(ts_now == '0, "R2 reset ts", int'(ts_now), 0);
    chk(grant == '0 && !grant_urgent, "R1 reset grant", int'(grant), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: counter step
    @(negedge clk);
    t0 = int'(ts_now);
    repeat (7) @(negedge clk);
    chk(int'(ts_now) == t0 + 7, "R2 ts increment", int'(ts_now), t0 + 7);

    // R5 with R3: single-slot sweep; ts_now is small so ages above it wrap
    for (int a = 0; a <= 130; a++) begin
      clear_model();
      m_v[1] = 1; m_e[1] = 1; m_t[1] = a % 2; m_age[1] = a;
      step_check("R3/R5 age sweep");
    end

    // R4: average rises, then falls
    for (int k = 0; k < 24; k++) complete(300);
    sweep_threshold("R4/R5 after high latencies");
    for (int k = 0; k < 40; k++) complete(20);
    sweep_threshold("R4/R5 after low latencies");

    // R7: tie goes to lowest index
    clear_model();
    m_v[2] = 1; m_e[2] = 1; m_age[2] = 10;
    m_v[5] = 1; m_e[5] = 1; m_age[5] = 10;
    m_v[6] = 1; m_e[6] = 1; m_age[6] = 9;
    step_check("R7 tie lowest index");

    // R8: ineligible urgent top blocks bottom
    clear_model();
    m_v[0] = 1; m_e[0] = 0; m_t[0] = 1; m_age[0] = thr_m() + 5;
    m_v[1] = 1; m_e[1] = 1; m_t[1] = 0; m_age[1] = thr_m() + 50;
    step_check("R8 bottom held, nothing grantable");
    m_v[3] = 1; m_e[3] = 1; m_t[3] = 1; m_age[3] = 2;
    step_check("R8 young top wins over held bottom");

    // R1: urgent but ineligible never granted
    clear_model();
    m_v[7] = 1; m_e[7] = 0; m_age[7] = thr_m() + 20;
    m_v[2] = 1; m_e[2] = 1; m_age[2] = 1;
    step_check("R1 ineligible urgent skipped");
    m_v[2] = 0;
    step_check("R1 R9 no grantable slot");

    // R6 R7 R8 R9 R10: pseudo-random patterns with forced ties
    for (int it = 0; it < 1500; it++) begin
      int span = thr_m() + 30;
      clear_model();
      for (int i = 0; i < N; i++) begin
        m_v[i] = int'($urandom % 4 != 0);
        m_e[i] = int'($urandom % 3 != 0);
        m_t[i] = int'($urandom % 2);
        m_age[i] = ($urandom % 5 == 0 && i > 0) ? m_age[0] : int'($urandom % span);
      end
      step_check("R6/R7/R8/R9/R10 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule